// File: doc/BRIEF.md
# Flag-Setting Integer ALU

A purely combinational data-processing unit for a 32-bit integer datapath. It takes two operands that the surrounding pipeline has already prepared: the first comes from a register, and the second has already been shifted or expanded from an immediate. It also takes the current N, Z, C and V condition flags, a 4-bit operation code, a set-flags request and the carry bit produced by the operand shifter. It returns the operation's value, a strobe that says whether that value is to be written back, and the next state of the four flags.

The arithmetic group covers addition, subtraction, subtraction with the operands swapped, and the carry-chained forms of all three. One adder serves every member of the group. Subtraction is done by adding the inverted subtrahend, so the carry flag ends up as the inverse of a borrow. The bitwise group covers AND, OR, exclusive-OR, bit-clear, and the two move forms. Four compare/test codes run the same datapath, but only their flags leave the block.

Top module: `flag_alu`

## Requirements
- R1: Opcode 4 (add) gives a+b. Opcode 5 (add with carry) gives a+b+C, where C is the incoming carry flag.
- R2: Opcode 2 gives a-b and opcode 3 gives b-a, both modulo 2^32.
- R3: Opcode 6 gives a-b+C-1 and opcode 7 gives b-a+C-1, both modulo 2^32.
- R4: Opcode 0 gives a AND b, opcode 1 gives a XOR b, opcode 12 gives a OR b, and opcode 14 gives a AND NOT b.
- R5: Opcode 13 gives b unchanged, and opcode 15 gives NOT b.
- R6: The write strobe is low for opcodes 8 to 11 and high for every other opcode. Opcodes 8 to 11 compute a AND b, a XOR b, a-b and a+b respectively.
- R7: When the set-flags input is low and the opcode is outside 8 to 11, all four output flags equal the incoming flags. Opcodes 8 to 11 update the flags whatever the set-flags input is.
- R8: When flags update, N equals bit 31 of the computed value, and Z is high exactly when all 32 bits of that value are zero.
- R9: When flags update for an arithmetic opcode (2 to 7, 10, 11), C is the carry out of the 32-bit addition x + y + k. Here a subtraction uses the inverted subtrahend, so C=1 means no borrow. V is high exactly when the signed result falls outside -2^31 .. 2^31-1.
- R10: When flags update for a bitwise opcode (0, 1, 8, 9, 12 to 15), C takes the shifter carry input and V keeps the incoming V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand (register side) |
| opnd_b | input | 32 | Second operand (already shifted) |
| opcode | input | 4 | Operation select, codes 0 to 15 |
| set_flags | input | 1 | Request to update flags |
| shift_carry | input | 1 | Carry out of the operand shifter |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| result | output | 32 | Computed value |
| result_we | output | 1 | Write-back strobe for result |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| v_out | output | 1 | Next overflow flag |

## Verification
Uniform random operands almost never give a zero result, a signed overflow, or an exact borrow boundary. As a result, Z and V, and the C-minus-one forms in their edge rows, would barely be exercised. The random stimulus therefore draws operands from a small pool of edge values (0, 1, all ones, 0x7FFFFFFF, 0x80000000) about half the time, and sometimes sets b equal to a. Directed vectors also cover the exact wrap points of each carry-chained form, with the carry flag both set and clear.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic op_is_arith(alu_op_e op);
        case (op)
            OP_SUB, OP_RSB, OP_ADD, OP_ADC,
            OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic op_is_flag_only(alu_op_e op);
        return (op == OP_TST) || (op == OP_TEQ) ||
               (op == OP_CMP) || (op == OP_CMN);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           carry_flag,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           ovf
);
    localparam int XW = W + 2;

    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic         k;
    } steer_t;

    steer_t steer_d;

    always_comb begin
        steer_d = '{x: a, y: b, k: 1'b0};
        case (op)
            OP_SUB, OP_CMP: steer_d = '{x: a, y: ~b, k: 1'b1};
            OP_RSB:         steer_d = '{x: b, y: ~a, k: 1'b1};
            OP_ADC:         steer_d = '{x: a, y: b,  k: carry_flag};
            OP_SBC:         steer_d = '{x: a, y: ~b, k: carry_flag};
            OP_RSC:         steer_d = '{x: b, y: ~a, k: carry_flag};
            default:        steer_d = '{x: a, y: b,  k: 1'b0};
        endcase
    end

    always_comb begin
        {cout, sum} = {1'b0, steer_d.x} + {1'b0, steer_d.y} + {{W{1'b0}}, steer_d.k};
        ovf = (steer_d.x[W-1] == steer_d.y[W-1]) && (sum[W-1] != steer_d.x[W-1]);
    end

    // Independent signed-width check of the overflow flag
    logic [XW-1:0] wide_sum;
    always_comb begin
        wide_sum = {{2{steer_d.x[W-1]}}, steer_d.x} + {{2{steer_d.y[W-1]}}, steer_d.y}
                 + {{(XW-1){1'b0}}, steer_d.k};
        // R9
        signed_range_chk: assert (ovf == (wide_sum[W] != wide_sum[W-1]))
            else $error("overflow flag disagrees with widened sum");
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   val
);
    always_comb begin
        case (op)
            OP_AND, OP_TST: val = a & b;
            OP_EOR, OP_TEQ: val = a ^ b;
            OP_ORR:         val = a | b;
            OP_MOV:         val = b;
            OP_BIC:         val = a & ~b;
            OP_MVN:         val = ~b;
            default:        val = '0;
        endcase
    end
endmodule

// File: rtl/alu_flagsel.sv
module alu_flagsel
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           update,
    input  logic           arith,
    input  logic [W-1:0]   value,
    input  logic           add_cout,
    input  logic           add_ovf,
    input  logic           shift_carry,
    input  nzcv_t          flags_in,
    output nzcv_t          flags_out
);
    always_comb begin
        flags_out = flags_in;
        if (update) begin
            flags_out.n = value[W-1];
            flags_out.z = ~|value;
            flags_out.c = arith ? add_cout : shift_carry;
            flags_out.v = arith ? add_ovf  : flags_in.v;
        end
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [3:0]  opcode,
    input  logic        set_flags,
    input  logic        shift_carry,
    input  logic        n_in,
    input  logic        z_in,
    input  logic        c_in,
    input  logic        v_in,
    output logic [31:0] result,
    output logic        result_we,
    output logic        n_out,
    output logic        z_out,
    output logic        c_out,
    output logic        v_out
);
    typedef struct packed {
        logic [W-1:0] value;
        logic         we;
        nzcv_t        flags;
    } alu_out_t;

    alu_op_e      op;
    logic         arith;
    logic         update;
    logic [W-1:0] sum;
    logic         add_cout;
    logic         add_ovf;
    logic [W-1:0] bit_val;
    nzcv_t        flags_in;
    nzcv_t        flags_nx;
    alu_out_t     out_d;

    assign op       = alu_op_e'(opcode);
    assign arith    = op_is_arith(op);
    assign update   = set_flags | op_is_flag_only(op);
    assign flags_in = '{n: n_in, z: z_in, c: c_in, v: v_in};

    alu_addsub #(.W(W)) i_addsub (
        .op         (op),
        .a          (opnd_a),
        .b          (opnd_b),
        .carry_flag (c_in),
        .sum        (sum),
        .cout       (add_cout),
        .ovf        (add_ovf)
    );

    alu_bitwise #(.W(W)) i_bitwise (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .val (bit_val)
    );

    alu_flagsel #(.W(W)) i_flagsel (
        .update      (update),
        .arith       (arith),
        .value       (out_d.value),
        .add_cout    (add_cout),
        .add_ovf     (add_ovf),
        .shift_carry (shift_carry),
        .flags_in    (flags_in),
        .flags_out   (flags_nx)
    );

    always_comb begin
        out_d.value = arith ? sum : bit_val;
        out_d.we    = ~op_is_flag_only(op);
        out_d.flags = flags_nx;
    end

    assign result    = out_d.value;
    assign result_we = out_d.we;
    assign n_out     = out_d.flags.n;
    assign z_out     = out_d.flags.z;
    assign c_out     = out_d.flags.c;
    assign v_out     = out_d.flags.v;

    always_comb begin
        // R7
        hold_flags_chk: assert (update || ({n_out, z_out, c_out, v_out} == {n_in, z_in, c_in, v_in}))
            else $error("flags moved without an update");
        // R8
        zero_flag_chk: assert (!update || (z_out == (result == '0)))
            else $error("Z does not match result");
        // R8
        neg_flag_chk: assert (!update || (n_out == result[W-1]))
            else $error("N does not match result sign");
        // R10
        logic_v_keep_chk: assert (!update || arith || (v_out == v_in && c_out == shift_carry))
            else $error("bitwise op disturbed V or ignored shifter carry");
        // R6
        compare_no_write_chk: assert (!(opcode[3:2] == 2'b10) || !result_we)
            else $error("compare/test requested a write");
    end

endmodule

// File: tb/test_flag_alu.sv
module test_flag_alu;

    logic        clk = 1'b0;
    logic [31:0] opnd_a, opnd_b, result;
    logic [3:0]  opcode;
    logic        set_flags, shift_carry, n_in, z_in, c_in, v_in;
    logic        result_we, n_out, z_out, c_out, v_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flag_alu i_flag_alu (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opcode(opcode), .set_flags(set_flags),
        .shift_carry(shift_carry), .n_in(n_in), .z_in(z_in), .c_in(c_in), .v_in(v_in),
        .result(result), .result_we(result_we), .n_out(n_out), .z_out(z_out),
        .c_out(c_out), .v_out(v_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: op=%0d a=%h b=%h actual=%h expected=%h",
                     req, what, opcode, opnd_a, opnd_b, act, exp);
        end
    endtask

    function automatic void model_add(input logic [31:0] x, input logic [31:0] y, input logic k,
                                      output logic [31:0] s, output logic c, output logic v);
        logic [63:0] t;
        longint sx;
        t  = {32'd0, x} + {32'd0, y} + {63'd0, k};
        s  = t[31:0];
        c  = t[32];
        sx = longint'($signed(x)) + longint'($signed(y)) + longint'(k);
        v  = (sx > 64'sd2147483647) || (sx < -64'sd2147483648);
    endfunction

    task automatic apply_and_check(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                                   input logic sf, input logic sc, input logic [3:0] fin);
        logic [31:0] er;
        logic ec, ev, ar, we, upd;
        string rq;
        @(posedge clk);
        #1;
        opnd_a = a; opnd_b = b; opcode = op; set_flags = sf; shift_carry = sc;
        {n_in, z_in, c_in, v_in} = fin;
        ar = 1'b1; ec = 1'b0; ev = 1'b0; er = '0;
        case (op)
            4'd0, 4'd8:  begin er = a & b;  ar = 0; rq = "R4"; end
            4'd1, 4'd9:  begin er = a ^ b;  ar = 0; rq = "R4"; end
            4'd12:       begin er = a | b;  ar = 0; rq = "R4"; end
            4'd14:       begin er = a & ~b; ar = 0; rq = "R4"; end
            4'd13:       begin er = b;      ar = 0; rq = "R5"; end
            4'd15:       begin er = ~b;     ar = 0; rq = "R5"; end
            4'd2, 4'd10: begin model_add(a, ~b, 1'b1, er, ec, ev); rq = "R2"; end
            4'd3:        begin model_add(b, ~a, 1'b1, er, ec, ev); rq = "R2"; end
            4'd4, 4'd11: begin model_add(a, b, 1'b0, er, ec, ev);  rq = "R1"; end
            4'd5:        begin model_add(a, b, fin[1], er, ec, ev); rq = "R1"; end
            4'd6:        begin model_add(a, ~b, fin[1], er, ec, ev); rq = "R3"; end
            default:     begin model_add(b, ~a, fin[1], er, ec, ev); rq = "R3"; end
        endcase
        we  = !(op >= 4'd8 && op <= 4'd11);
        upd = sf || !we;
        #2;
        chk("R6", "result_we", {31'd0, result_we}, {31'd0, we});
        if (we) chk(rq, "result", result, er);
        if (!upd) begin
            chk("R7", "held flags", {28'd0, n_out, z_out, c_out, v_out}, {28'd0, fin});
        end else begin
            chk("R8", "N", {31'd0, n_out}, {31'd0, er[31]});
            chk("R8", "Z", {31'd0, z_out}, {31'd0, er == 32'd0});
            if (ar) begin
                chk("R9", "C", {31'd0, c_out}, {31'd0, ec});
                chk("R9", "V", {31'd0, v_out}, {31'd0, ev});
            end else begin
                chk("R10", "C", {31'd0, c_out}, {31'd0, sc});
                chk("R10", "V", {31'd0, v_out}, {31'd0, fin[0]});
            end
        end
    endtask

    function automatic logic [31:0] pick_operand();
        logic [31:0] pool [5];
        pool[0] = 32'h0; pool[1] = 32'h1; pool[2] = 32'hFFFF_FFFF;
        pool[3] = 32'h7FFF_FFFF; pool[4] = 32'h8000_0000;
        if ($urandom_range(1, 0) == 0) return pool[$urandom_range(4, 0)];
        return $urandom();
    endfunction

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        opnd_a = '0; opnd_b = '0; opcode = 4'd13; set_flags = 0; shift_carry = 0;
        {n_in, z_in, c_in, v_in} = 4'b0000;
        #2;
        // R5: idle state: move of zero writes zero, flags held (R7)
        chk("R5", "initial result", result, 32'd0);
        chk("R7", "initial flags", {28'd0, n_out, z_out, c_out, v_out}, 32'd0);

        // R1 / R9: signed overflow and unsigned carry to zero
        apply_and_check(32'h7FFF_FFFF, 32'h1, 4'd4, 1, 0, 4'b0000);
        apply_and_check(32'hFFFF_FFFF, 32'h1, 4'd4, 1, 0, 4'b0000);
        apply_and_check(32'hFFFF_FFFF, 32'h0, 4'd5, 1, 0, 4'b0010);
        // R2: equal operands give zero with no borrow
        apply_and_check(32'h1234_5678, 32'h1234_5678, 4'd2, 1, 0, 4'b0000);
        apply_and_check(32'h5, 32'h3, 4'd3, 1, 0, 4'b0000);
        apply_and_check(32'h8000_0000, 32'h1, 4'd2, 1, 0, 4'b0000);
        // R3: carry-minus-one forms, carry clear and set
        apply_and_check(32'h0, 32'h0, 4'd6, 1, 0, 4'b0000);
        apply_and_check(32'h0, 32'h0, 4'd6, 1, 0, 4'b0010);
        apply_and_check(32'h0, 32'h0, 4'd7, 1, 0, 4'b0000);
        apply_and_check(32'h9, 32'h4, 4'd7, 1, 0, 4'b0010);
        // R6 / R7: compare/test update even with set_flags low
        apply_and_check(32'hF0F0_0000, 32'h0F0F_0000, 4'd8, 0, 1, 4'b0001);
        apply_and_check(32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'd9, 0, 0, 4'b1111);
        apply_and_check(32'h3, 32'h3, 4'd10, 0, 0, 4'b0000);
        apply_and_check(32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'd11, 0, 0, 4'b0000);
        // R7: set_flags low holds flags for writing ops
        apply_and_check(32'h0, 32'h0, 4'd4, 0, 1, 4'b1010);
        apply_and_check(32'h0, 32'h0, 4'd0, 0, 1, 4'b0101);
        // R4 / R5 / R10
        apply_and_check(32'hFF00_FF00, 32'h0F0F_0F0F, 4'd14, 1, 1, 4'b0001);
        apply_and_check(32'h0, 32'h0, 4'd15, 1, 0, 4'b0000);
        apply_and_check(32'h0, 32'h8000_0000, 4'd13, 1, 1, 4'b0000);
        apply_and_check(32'h0000_00F0, 32'h0000_000F, 4'd12, 1, 0, 4'b0001);
        apply_and_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd1, 1, 1, 4'b0000);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            a = pick_operand();
            b = ($urandom_range(7, 0) == 0) ? a : pick_operand();
            apply_and_check(a, b, 4'($urandom_range(15, 0)), 1'($urandom_range(1, 0)),
                            1'($urandom_range(1, 0)), 4'($urandom_range(15, 0)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule